// File: doc/BRIEF.md
# Register Renaming Map Table

This block sits in the front end of an out-of-order core and translates the register numbers of one instruction per cycle from the architectural name space into the physical name space. Each request carries two source register numbers and one destination register number, all 5 bits wide. The sources are translated through the current mapping. The destination is given a fresh physical register taken from a free pool. The mapping is then updated so that every later instruction reading that architectural register sees the new physical tag.

Because every written register gets its own physical copy, two writes to the same architectural register, or a read followed by a write, no longer constrain the order in which a scheduler can execute them. Only true producer-to-consumer dependences remain. Physical tags that the back end no longer needs come back through a release port and join the tail of the pool. When the pool is empty, an instruction that needs a destination is held off with a stall. Instructions that write nothing, or that write register 0, pass through without using a tag.

Top module: `reg_rename_top`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for every i in 0..ARCH_REGS-1.
- R2: Both source tags come from the mapping as it stood before the same instruction's destination update, so a source equal to the destination returns the old tag.
- R3: An allocating instruction receives the tag at the head of the free pool. After reset the pool holds tags ARCH_REGS..PHYS_REGS-1 in ascending order.
- R4: Once an allocation is accepted, every later lookup of that architectural register returns the newly allocated tag.
- R5: When dst_en is 0 or dst_reg is 0, no tag is taken from the pool, the mapping does not change, and the result shows dst_alloc=0 with dst_ptag=0.
- R6: stall is 1 exactly when req_valid=1, the instruction needs a destination, and the pool is empty. A stalled request changes neither the mapping nor the pool, and produces no result.
- R7: A tag presented with rel_valid=1 is appended to the tail of the pool and is handed out after every tag already in the pool.
- R8: An instruction that needs no destination is accepted even when the pool is empty.
- R9: Results are registered. res_valid is 1 in the cycle after an accepted request and 0 otherwise, and it is 0 after reset.
- R10: Architectural register 0 always translates to physical tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A rename request is presented |
| src0_reg | input | 5 | First source architectural register |
| src1_reg | input | 5 | Second source architectural register |
| dst_reg | input | 5 | Destination architectural register |
| dst_en | input | 1 | The instruction writes dst_reg |
| stall | output | 1 | Request not accepted this cycle: no free tag |
| res_valid | output | 1 | Result of the request accepted last cycle |
| src0_ptag | output | 7 | Physical tag of the first source |
| src1_ptag | output | 7 | Physical tag of the second source |
| dst_ptag | output | 7 | Newly allocated destination tag (0 if none) |
| dst_alloc | output | 1 | A destination tag was allocated |
| rel_valid | input | 1 | Return a physical tag to the pool |
| rel_ptag | input | 7 | Tag being returned |

## Verification
On every cycle, the assertions check the stall condition against the pool state, the result timing after accepted and stalled requests, the zero tag for both a non-allocating destination and a register-0 source, and the bound on pool occupancy. Only the bench scenarios can show that translated values are correct. These scenarios cover the reset identity mapping, the read-before-update ordering when a source equals its destination, the ascending order of allocation, the first-in first-out reuse of released tags, and a mapping left untouched after stalled and non-allocating requests. The bench keeps its own mapping table and tag queue to compute these values.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int DEF_ARCH_REGS = 32;
    localparam int DEF_PHYS_REGS = 128;
endpackage

// File: rtl/rename_map.sv
module rename_map #(
    parameter int ARCH_REGS = rename_pkg::DEF_ARCH_REGS,
    parameter int PHYS_REGS = rename_pkg::DEF_PHYS_REGS,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd0_reg,
    input  logic [AW-1:0] rd1_reg,
    output logic [TW-1:0] rd0_tag,
    output logic [TW-1:0] rd1_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_reg,
    input  logic [TW-1:0] wr_tag
);
    typedef logic [ARCH_REGS-1:0][TW-1:0] table_t;

    function automatic table_t identity_map();
        table_t t;
        for (int i = 0; i < ARCH_REGS; i++) t[i] = TW'(i);
        return t;
    endfunction

    table_t tbl_d, tbl_q;

    // reads see the table as it stands before this cycle's write
    assign rd0_tag = tbl_q[rd0_reg];
    assign rd1_tag = tbl_q[rd1_reg];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (wr_reg != '0)) tbl_d[wr_reg] = wr_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= identity_map();
        else        tbl_q <= tbl_d;
    end
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
    parameter int ARCH_REGS = rename_pkg::DEF_ARCH_REGS,
    parameter int PHYS_REGS = rename_pkg::DEF_PHYS_REGS,
    localparam int TW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    output logic [TW-1:0] head_tag,
    output logic          empty,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    output logic [TW:0]   occupancy
);
    localparam int INIT_FREE = PHYS_REGS - ARCH_REGS;

    typedef struct packed {
        logic [PHYS_REGS-1:0][TW-1:0] mem;
        logic [TW-1:0]                rd;
        logic [TW-1:0]                wr;
        logic [TW:0]                  cnt;
    } fl_t;

    function automatic fl_t reset_state();
        fl_t s;
        for (int i = 0; i < PHYS_REGS; i++)
            s.mem[i] = (i < INIT_FREE) ? TW'(i + ARCH_REGS) : '0;
        s.rd  = '0;
        s.wr  = TW'(INIT_FREE);
        s.cnt = (TW+1)'(INIT_FREE);
        return s;
    endfunction

    fl_t st_d, st_q;
    logic push_ok, pop_ok;

    assign empty     = (st_q.cnt == '0);
    assign head_tag  = st_q.mem[st_q.rd];
    assign occupancy = st_q.cnt;

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && !empty;
        push_ok = push && (st_q.cnt != (TW+1)'(PHYS_REGS));
        if (pop_ok) st_d.rd = st_q.rd + 1'b1;
        if (push_ok) begin
            st_d.mem[st_q.wr] = push_tag;
            st_d.wr           = st_q.wr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/reg_rename_top.sv
module reg_rename_top #(
    parameter int ARCH_REGS = rename_pkg::DEF_ARCH_REGS,
    parameter int PHYS_REGS = rename_pkg::DEF_PHYS_REGS,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] src0_reg,
    input  logic [AW-1:0] src1_reg,
    input  logic [AW-1:0] dst_reg,
    input  logic          dst_en,
    output logic          stall,
    output logic          res_valid,
    output logic [TW-1:0] src0_ptag,
    output logic [TW-1:0] src1_ptag,
    output logic [TW-1:0] dst_ptag,
    output logic          dst_alloc,
    input  logic          rel_valid,
    input  logic [TW-1:0] rel_ptag
);
    typedef struct packed {
        logic          valid;
        logic          alloc;
        logic [TW-1:0] s0;
        logic [TW-1:0] s1;
        logic [TW-1:0] d;
    } res_t;

    res_t res_d, res_q;

    logic          need_dst, accept, do_alloc, fl_empty;
    logic [TW-1:0] tag0, tag1, fl_head;
    logic [TW:0]   fl_occ;

    rename_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
        .clk(clk), .rst_n(rst_n),
        .rd0_reg(src0_reg), .rd1_reg(src1_reg),
        .rd0_tag(tag0), .rd1_tag(tag1),
        .wr_en(do_alloc), .wr_reg(dst_reg), .wr_tag(fl_head)
    );

    rename_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
        .clk(clk), .rst_n(rst_n),
        .pop(do_alloc), .head_tag(fl_head), .empty(fl_empty),
        .push(rel_valid), .push_tag(rel_ptag), .occupancy(fl_occ)
    );

    always_comb begin
        need_dst = dst_en && (dst_reg != '0);
        stall    = req_valid && need_dst && fl_empty;
        accept   = req_valid && !stall;
        do_alloc = accept && need_dst;

        res_d       = '0;
        res_d.valid = accept;
        if (accept) begin
            res_d.s0    = tag0;
            res_d.s1    = tag1;
            res_d.alloc = do_alloc;
            res_d.d     = do_alloc ? fl_head : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign dst_alloc = res_q.alloc;
    assign src0_ptag = res_q.s0;
    assign src1_ptag = res_q.s1;
    assign dst_ptag  = res_q.d;
endmodule

// File: rtl/rename_chk.sv
module rename_chk #(
    parameter int AW = 5,
    parameter int TW = 7,
    parameter int PHYS_REGS = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] src0_reg,
    input logic [AW-1:0] src1_reg,
    input logic [AW-1:0] dst_reg,
    input logic          dst_en,
    input logic          stall,
    input logic          res_valid,
    input logic [TW-1:0] src0_ptag,
    input logic [TW-1:0] src1_ptag,
    input logic [TW-1:0] dst_ptag,
    input logic          dst_alloc,
    input logic          fl_empty,
    input logic [TW:0]   fl_occ
);
    a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (req_valid && dst_en && (dst_reg != '0) && fl_empty));

    a_r6_stall_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dst_en && (dst_reg != '0) && fl_empty) |-> stall);

    a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall) |=> res_valid);

    a_r6_no_result_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || stall) |=> !res_valid);

    a_r5_zero_when_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_alloc |-> (dst_ptag == '0));

    a_r5_no_alloc_for_r0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (dst_reg == '0)) |=> !dst_alloc);

    a_r10_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall && (src0_reg == '0) && (src1_reg == '0))
        |=> (src0_ptag == '0 && src1_ptag == '0));

    a_r7_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fl_occ <= (TW+1)'(PHYS_REGS));
endmodule

bind reg_rename_top rename_chk #(.AW(AW), .TW(TW), .PHYS_REGS(PHYS_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .src0_reg(src0_reg), .src1_reg(src1_reg), .dst_reg(dst_reg), .dst_en(dst_en),
    .stall(stall), .res_valid(res_valid), .src0_ptag(src0_ptag), .src1_ptag(src1_ptag),
    .dst_ptag(dst_ptag), .dst_alloc(dst_alloc), .fl_empty(fl_empty), .fl_occ(fl_occ)
);

// File: tb/sim_reg_rename_top.sv
`timescale 1ns/1ps
module sim_reg_rename_top;
    localparam int ARCH = 32;
    localparam int PHYS = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] src0_reg = '0, src1_reg = '0, dst_reg = '0;
    logic       dst_en = 1'b0;
    logic       stall, res_valid, dst_alloc;
    logic [6:0] src0_ptag, src1_ptag, dst_ptag;
    logic       rel_valid = 1'b0;
    logic [6:0] rel_ptag = '0;

    int total = 0;
    int bad = 0;
    int model_map [ARCH];
    int pool [$];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    reg_rename_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .src0_reg(src0_reg), .src1_reg(src1_reg), .dst_reg(dst_reg), .dst_en(dst_en),
        .stall(stall), .res_valid(res_valid), .src0_ptag(src0_ptag), .src1_ptag(src1_ptag),
        .dst_ptag(dst_ptag), .dst_alloc(dst_alloc), .rel_valid(rel_valid), .rel_ptag(rel_ptag)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic rename(input int a, input int b, input int d, input bit de, input string req);
        bit need, exp_stall;
        int e0, e1;
        need      = de && (d != 0);
        exp_stall = need && (pool.size() == 0);
        e0        = model_map[a];
        e1        = model_map[b];
        req_valid = 1'b1;
        src0_reg  = 5'(a);
        src1_reg  = 5'(b);
        dst_reg   = 5'(d);
        dst_en    = de;
        #1;
        chk(stall == exp_stall, req, "stall", int'(stall), int'(exp_stall));
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_stall) begin
            chk(res_valid == 1'b0, req, "res_valid after stall", int'(res_valid), 0);
        end else begin
            chk(res_valid == 1'b1, req, "res_valid", int'(res_valid), 1);
            chk(int'(src0_ptag) == e0, req, "src0_ptag", int'(src0_ptag), e0);
            chk(int'(src1_ptag) == e1, req, "src1_ptag", int'(src1_ptag), e1);
            if (need) begin
                chk(dst_alloc == 1'b1, req, "dst_alloc", int'(dst_alloc), 1);
                chk(int'(dst_ptag) == pool[0], req, "dst_ptag", int'(dst_ptag), pool[0]);
                model_map[d] = pool.pop_front();
            end else begin
                chk(dst_alloc == 1'b0, req, "dst_alloc", int'(dst_alloc), 0);
                chk(dst_ptag == '0, req, "dst_ptag", int'(dst_ptag), 0);
            end
        end
    endtask

    task automatic release_tag(input int t);
        rel_valid = 1'b1;
        rel_ptag  = 7'(t);
        @(negedge clk);
        rel_valid = 1'b0;
        pool.push_back(t);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ARCH; i++) model_map[i] = i;
        for (int t = ARCH; t < PHYS; t++) pool.push_back(t);

        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R9", "res_valid in reset", int'(res_valid), 0);
        chk(stall == 1'b0, "R6", "stall in reset", int'(stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R9", "res_valid idle", int'(res_valid), 0);

        // R1 / R10: identity mapping after reset, read without destination
        for (int r = 0; r < ARCH; r++) rename(r, ARCH - 1 - r, r, 1'b0, "R1");
        rename(0, 0, 0, 1'b0, "R10");

        // R2 / R3 / R4: drain the whole pool; each source equals its destination
        for (int i = 0; i < PHYS - ARCH; i++)
            rename((i % 31) + 1, (i * 7) % ARCH, (i % 31) + 1, 1'b1, "R3");
        rename(4, 4, 4, 1'b0, "R4");

        // R6: empty pool stalls an allocating request and leaves the mapping alone
        rename(3, 9, 9, 1'b1, "R6");
        rename(9, 3, 0, 1'b0, "R6");
        // R8: a request with no destination still proceeds
        rename(12, 13, 12, 1'b0, "R8");
        rename(0, 1, 0, 1'b1, "R8");

        // R7: released tags come back in release order
        release_tag(40);
        release_tag(7);
        release_tag(100);
        rename(9, 9, 9, 1'b1, "R7");
        rename(9, 2, 2, 1'b1, "R7");
        rename(2, 9, 30, 1'b1, "R7");
        rename(30, 2, 30, 1'b1, "R7");

        // R5: no destination enable, or destination r0, allocates nothing
        release_tag(55);
        rename(0, 5, 0, 1'b1, "R5");
        rename(5, 0, 5, 1'b0, "R5");
        rename(5, 5, 0, 1'b0, "R5");
        rename(5, 6, 5, 1'b1, "R5");
        rename(5, 5, 0, 1'b0, "R4");
        rename(0, 0, 0, 1'b0, "R10");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule